// File: doc/BRIEF.md
# Wide-Row SECDED Read Path with Target-Qualified Error Flags

This block sits between a requester and a memory bank whose rows are 144 bits wide. A row carries two 72-bit codewords, each made of a 64-bit data word and its own 8-bit check byte. Every access fetches the complete row, and both codewords are decoded in parallel by two SECDED checkers. Only the codeword that the access actually addresses may raise the correctable or uncorrectable error flag. Whatever is found in the neighbouring codeword of the same row is discarded.

The requester issues either a data read of 1, 2, 4 or 8 bytes, or a one-byte read of a codeword's check byte. The same target qualification applies to both kinds. A data read returns the corrected word with the unrequested byte lanes cleared. A check-byte read returns the stored check byte exactly as held in the array. The array answers one cycle after the fetch strobe, and the result, the valid strobe and any flag appear one cycle after that. A new request is accepted on every cycle.

Top module: `wide_row_ecc_rd`

## Requirements
- R1: While `req_valid_i` is high, `row_rd_o` is high in the same cycle. For a data read, `row_idx_o` equals `req_addr_i[ADDR_W-1:4]`. For a check-byte read (`req_chk_i`=1), it equals `req_addr_i[ADDR_W-4:1]`.
- R2: A request sampled at clock edge k gives exactly one `rvalid_o` pulse, seen after edge k+2. No `rvalid_o` appears without a request.
- R3: The target half is `req_addr_i[3]` for a data read and `req_addr_i[0]` for a check-byte read. A data read returns the corrected 64-bit target word on `rdata_o`.
  - Bytes from offset `req_addr_i[2:0]` to that offset plus 2^`req_size_i` minus 1 are kept, where size 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
  - All other bytes read as zero.
  - Accesses are naturally aligned.
- R4: A check-byte read returns the stored, uncorrected check byte of the target half on `rdata_o[7:0]`, with `rdata_o[63:8]` zero.
- R5: A single-bit error in the target codeword (data bit, check bit or overall parity bit) pulses `err_corr_o` together with `rvalid_o`, and the returned data is corrected.
- R6: A double-bit error in the target codeword pulses `err_unc_o` with `rvalid_o`. `err_corr_o` and `err_unc_o` are never high together.
- R7: On a data read, a single-bit or double-bit error in the non-targeted codeword of the row raises no flag.
- R8: On a check-byte read, a single-bit or double-bit error in the non-targeted codeword of the row raises no flag.
- R9: The error flags are high only in a cycle in which `rvalid_o` is high.
- R10: Row layout and check-byte encoding:
  - Bits [63:0] hold word 0 and bits [127:64] hold word 1.
  - Bits [135:128] hold check byte 0 and bits [143:136] hold check byte 1.
  - Data bit j occupies the j-th non-power-of-two code position, counting upward from position 3 through 71.
  - Check bit i (i = 0..6) is the XOR of the data bits whose position has bit i set.
  - Check bit 7 makes the XOR of all 72 bits zero.
  - A nonzero syndrome with even overall parity, or a syndrome above 71, is uncorrectable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request strobe |
| req_chk_i | input | 1 | 1 = check-byte read, 0 = data read |
| req_addr_i | input | ADDR_W | Byte address (data) or check-byte address |
| req_size_i | input | 2 | Data read size, 2^n bytes |
| row_rd_o | output | 1 | Row fetch strobe to the array |
| row_idx_o | output | ADDR_W-4 | Row index to the array |
| row_data_i | input | 144 | Row contents, one cycle after the fetch |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 64 | Read data |
| err_corr_o | output | 1 | Correctable error in target codeword |
| err_unc_o | output | 1 | Uncorrectable error in target codeword |

## Verification
Two things can happen in the same cycle: the decoder of the targeted codeword returns one result while the decoder of the neighbouring codeword reports a different error class. The bench provokes this with rows that carry a single-bit error in one half and a double-bit error in the other, and reads both halves by data reads and by check-byte reads. Some of these reads are issued back to back, so consecutive results come from opposite halves on consecutive cycles. Each result is judged against a scoreboard entry. That entry holds the flags implied by the error injected into the targeted half only, and the data expected from the clean word or from the stored check byte.

// File: rtl/ecc_row_pkg.sv
package ecc_row_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned CHK_W    = 8;
  localparam int unsigned HAM_W    = 7;
  localparam int unsigned LAST_POS = 71;
  localparam int unsigned HALF_N   = 2;
  localparam int unsigned BYTES_N  = WORD_W / 8;
  localparam int unsigned ROW_W    = HALF_N * (WORD_W + CHK_W);

  // Hamming parity: data bits sit on non-power-of-two positions from 3 upward
  function automatic logic [HAM_W-1:0] ham_par(input logic [WORD_W-1:0] d);
    logic [HAM_W-1:0] p;
    int unsigned pos;
    p   = '0;
    pos = 3;
    for (int j = 0; j < WORD_W; j++) begin
      if (d[j]) p = p ^ HAM_W'(pos);
      pos = pos + 1;
      if ((pos & (pos - 1)) == 0) pos = pos + 1;
    end
    return p;
  endfunction

  function automatic logic [WORD_W-1:0] ham_fix(input logic [WORD_W-1:0] d,
                                                input logic [HAM_W-1:0]  syn);
    logic [WORD_W-1:0] r;
    int unsigned pos;
    r   = d;
    pos = 3;
    for (int j = 0; j < WORD_W; j++) begin
      if (HAM_W'(pos) == syn) r[j] = ~d[j];
      pos = pos + 1;
      if ((pos & (pos - 1)) == 0) pos = pos + 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_cw_check.sv
module ecc_cw_check
  import ecc_row_pkg::*;
(
  input  logic [WORD_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [WORD_W-1:0] data_o,
  output logic              single_o,
  output logic              double_o
);
  logic [HAM_W-1:0] syn;
  logic             odd;
  logic             bad_pos;

  assign syn     = ham_par(data_i) ^ chk_i[HAM_W-1:0];
  assign odd     = ^{data_i, chk_i};
  assign bad_pos = syn > HAM_W'(LAST_POS);

  assign single_o = odd & ~bad_pos;
  assign double_o = ((syn != '0) & ~odd) | (odd & bad_pos);
  assign data_o   = ham_fix(data_i, syn);
endmodule

// File: rtl/ecc_req_map.sv
module ecc_req_map
  import ecc_row_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned RIDX_W = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         size_i,
  input  logic               chk_i,
  output logic [RIDX_W-1:0]  row_o,
  output logic               half_o,
  output logic [BYTES_N-1:0] lane_o
);
  logic [3:0]  nbytes;
  logic [15:0] span;
  logic [15:0] shifted;

  assign nbytes  = 4'd1 << size_i;
  assign span    = (16'd1 << nbytes) - 16'd1;
  assign shifted = span << addr_i[2:0];

  // check-byte region: two bytes per row, bit 0 picks the half
  assign row_o  = chk_i ? addr_i[RIDX_W:1] : addr_i[ADDR_W-1:4];
  assign half_o = chk_i ? addr_i[0] : addr_i[3];
  assign lane_o = chk_i ? BYTES_N'(1) : shifted[BYTES_N-1:0];
endmodule

// File: rtl/wide_row_ecc_rd.sv
module wide_row_ecc_rd
  import ecc_row_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned RIDX_W = ADDR_W - 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_chk_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  output logic              row_rd_o,
  output logic [RIDX_W-1:0] row_idx_o,
  input  logic [ROW_W-1:0]  row_data_i,
  output logic              rvalid_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              err_corr_o,
  output logic              err_unc_o
);
  localparam int unsigned CHK_BASE = HALF_N * WORD_W;

  logic               map_half;
  logic [BYTES_N-1:0] map_lane;

  ecc_req_map #(.ADDR_W(ADDR_W)) i_map (
    .addr_i (req_addr_i),
    .size_i (req_size_i),
    .chk_i  (req_chk_i),
    .row_o  (row_idx_o),
    .half_o (map_half),
    .lane_o (map_lane)
  );

  assign row_rd_o = req_valid_i;

  // stage 1: request attributes wait for the array
  logic               s1_vld, s1_chk, s1_half;
  logic [BYTES_N-1:0] s1_lane;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_chk  <= 1'b0;
      s1_half <= 1'b0;
      s1_lane <= '0;
    end else begin
      s1_vld <= req_valid_i;
      if (req_valid_i) begin
        s1_chk  <= req_chk_i;
        s1_half <= map_half;
        s1_lane <= map_lane;
      end
    end
  end

  // both codewords checked in parallel
  logic [WORD_W-1:0] fix_data [HALF_N];
  logic [CHK_W-1:0]  raw_chk  [HALF_N];
  logic [HALF_N-1:0] is_single, is_double;

  for (genvar h = 0; h < HALF_N; h++) begin : g_half
    assign raw_chk[h] = row_data_i[CHK_BASE + h*CHK_W +: CHK_W];
    ecc_cw_check i_chk (
      .data_i   (row_data_i[h*WORD_W +: WORD_W]),
      .chk_i    (raw_chk[h]),
      .data_o   (fix_data[h]),
      .single_o (is_single[h]),
      .double_o (is_double[h])
    );
    a_r6_dec_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s1_vld |-> !(is_single[h] && is_double[h]));
  end

  logic [WORD_W-1:0] lane_bits;
  for (genvar b = 0; b < BYTES_N; b++) begin : g_lane
    assign lane_bits[b*8 +: 8] = {8{s1_lane[b]}};
  end

  logic [WORD_W-1:0] rdata_d;
  logic              corr_d, unc_d;

  // only the targeted half may flag, for data and check-byte reads alike
  always_comb begin
    if (s1_chk) rdata_d = WORD_W'(raw_chk[s1_half]);
    else        rdata_d = fix_data[s1_half] & lane_bits;
    unc_d  = s1_vld & is_double[s1_half];
    corr_d = s1_vld & is_single[s1_half] & ~is_double[s1_half];
  end

  logic rd_chk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o   <= 1'b0;
      rdata_o    <= '0;
      err_corr_o <= 1'b0;
      err_unc_o  <= 1'b0;
      rd_chk_q   <= 1'b0;
    end else begin
      rvalid_o   <= s1_vld;
      err_corr_o <= corr_d;
      err_unc_o  <= unc_d;
      if (s1_vld) begin
        rdata_o  <= rdata_d;
        rd_chk_q <= s1_chk;
      end
    end
  end

  a_r9_flags_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_corr_o || err_unc_o) |-> rvalid_o);
  a_r6_flags_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_corr_o, err_unc_o}));
  a_r2_two_edge_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ##1 rvalid_o);
  a_r4_chk_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && rd_chk_q) |-> (rdata_o[WORD_W-1:CHK_W] == '0));
endmodule

// File: tb/test_wide_row_ecc_rd.sv
module test_wide_row_ecc_rd;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int RIDX_W = ADDR_W - 4;
  localparam int ROWS   = 1 << RIDX_W;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              req_valid = 1'b0, req_chk = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = '0;
  logic              row_rd;
  logic [RIDX_W-1:0] row_idx;
  logic [143:0]      row_data = '0;
  logic              rvalid, err_corr, err_unc;
  logic [63:0]       rdata;

  wide_row_ecc_rd #(.ADDR_W(ADDR_W)) i_wide_row_ecc_rd (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_chk_i(req_chk),
    .req_addr_i(req_addr), .req_size_i(req_size), .row_rd_o(row_rd),
    .row_idx_o(row_idx), .row_data_i(row_data), .rvalid_o(rvalid),
    .rdata_o(rdata), .err_corr_o(err_corr), .err_unc_o(err_unc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [143:0] mem  [ROWS];
  logic [63:0]  gold [ROWS][2];
  int           errt [ROWS][2]; // 0 none, 1 single, 2 double

  always @(posedge clk) if (row_rd) row_data <= mem[row_idx];

  int  tests = 0, fails = 0;
  bit  done  = 1'b0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R10 encoding, positions 1..71
  function automatic logic [7:0] enc(input logic [63:0] d);
    logic [71:0] cw;
    logic [6:0]  p;
    int          j;
    cw = '0; p = '0; j = 0;
    for (int pos = 1; pos <= 71; pos++)
      if ((pos & (pos - 1)) != 0) begin cw[pos] = d[j]; j++; end
    for (int i = 0; i < 7; i++)
      for (int pos = 1; pos <= 71; pos++)
        if (((pos >> i) & 1) == 1) p[i] = p[i] ^ cw[pos];
    return {(^d) ^ (^p), p};
  endfunction

  task automatic put(int r, int h, logic [63:0] d);
    gold[r][h] = d;
    errt[r][h] = 0;
    mem[r][64*h +: 64]   = d;
    mem[r][128+8*h +: 8] = enc(d);
  endtask

  task automatic flip_d(int r, int h, int j); mem[r][64*h + j] = ~mem[r][64*h + j]; endtask
  task automatic flip_c(int r, int h, int k); mem[r][128+8*h+k] = ~mem[r][128+8*h+k]; endtask

  typedef struct packed {
    logic [63:0] d;
    logic        cmp;
    logic        corr;
    logic        unc;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  task automatic rd(int r, int h, int size, int off, bit chk, string tag);
    exp_t e;
    logic [63:0] mask;
    mask = '0;
    for (int b = 0; b < 8; b++)
      if (b >= off && b < off + (1 << size)) mask[8*b +: 8] = 8'hff;
    e.d    = chk ? {56'b0, mem[r][128+8*h +: 8]} : (gold[r][h] & mask);
    e.corr = errt[r][h] == 1;
    e.unc  = errt[r][h] == 2;
    e.cmp  = chk || errt[r][h] != 2;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_valid = 1'b1;
    req_chk   = chk;
    req_size  = 2'(size);
    req_addr  = chk ? ADDR_W'((r << 1) | h) : ADDR_W'((r << 4) | (h << 3) | off);
    #1;
    check(row_rd && row_idx == RIDX_W'(r), "R1", "row fetch", {59'b0, row_rd, row_idx},
          {59'b0, 1'b1, 4'(r)});
    @(negedge clk);
  endtask

  task automatic idle(int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rvalid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected rvalid", 64'd1, 64'd0);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (e.cmp) check(rdata == e.d, t, "rdata", rdata, e.d);
          check(err_corr == e.corr && err_unc == e.unc, t, "flags{corr,unc}",
                {62'b0, err_corr, err_unc}, {62'b0, e.corr, e.unc});
        end
      end else if (err_corr || err_unc) begin
        check(1'b0, "R9", "flag without rvalid", {62'b0, err_corr, err_unc}, 64'd0);
      end
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int h = 0; h < 2; h++)
        put(r, h, 64'h9e37_79b9_7f4a_7c15 * 64'(r * 2 + h + 1) ^ 64'h0123_4567_89ab_cdef);
    // r1: single in half1; r2: double in half1
    flip_d(1, 1, 10);                   errt[1][1] = 1;
    flip_d(2, 1, 3);  flip_d(2, 1, 40); errt[2][1] = 2;
    // r3: single on check bit in half0, double (data + overall parity) in half1
    flip_c(3, 0, 2);                    errt[3][0] = 1;
    flip_d(3, 1, 0);  flip_c(3, 1, 7);  errt[3][1] = 2;
    // r4: double in half0, single on top data bit in half1
    flip_d(4, 0, 5);  flip_c(4, 0, 0);  errt[4][0] = 2;
    flip_d(4, 1, 63);                   errt[4][1] = 1;
    // r5: single on overall parity bit in half0
    flip_c(5, 0, 7);                    errt[5][0] = 1;

    repeat (3) @(negedge clk);
    check(rvalid == 0 && err_corr == 0 && err_unc == 0 && rdata == 0, "R2", "reset state",
          {rdata[60:0], rvalid, err_corr, err_unc}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    rd(0, 0, 3, 0, 0, "R3");
    rd(0, 1, 2, 4, 0, "R3");
    rd(0, 1, 1, 2, 0, "R3");
    rd(0, 0, 0, 7, 0, "R3");
    idle(2);
    rd(0, 1, 0, 0, 1, "R4");
    idle(1);
    rd(1, 0, 3, 0, 0, "R7");
    rd(1, 0, 0, 0, 1, "R8");
    rd(1, 1, 3, 0, 0, "R5");
    rd(1, 1, 0, 0, 1, "R5");
    idle(3);
    rd(2, 0, 0, 3, 0, "R7");
    rd(2, 0, 0, 0, 1, "R8");
    rd(2, 1, 3, 0, 0, "R6");
    rd(2, 1, 0, 0, 1, "R6");
    idle(1);
    rd(3, 0, 3, 0, 0, "R5");
    rd(3, 0, 0, 0, 1, "R4");
    rd(3, 1, 2, 0, 0, "R6");
    rd(3, 0, 1, 6, 0, "R7");
    idle(2);
    rd(4, 1, 3, 0, 0, "R5");
    rd(4, 1, 0, 0, 1, "R8");
    rd(4, 0, 0, 0, 1, "R6");
    rd(4, 1, 0, 7, 0, "R7");
    rd(5, 0, 3, 0, 0, "R5");
    rd(5, 1, 3, 0, 0, "R7");
    rd(5, 1, 0, 0, 1, "R8");
    idle(6);
    check(exp_q.size() == 0 && rvalid == 0, "R2", "drained, no extra valid",
          64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule